// File: doc/BRIEF.md
# Slave-Mode Audio Serial Transmit Formatter

This block places sense and status words on a shared serial data line. An external master supplies a bit clock and a word clock. The block samples both with its own system clock and detects their edges there. On each bit clock edge where the line may change (the drive edge), it works out which channel and which bit position the next sampling edge belongs to. It then drives one data bit together with an output enable. The pad logic combines the two into a three-state pin.

Four frame formats are supported: I2S, left-justified, right-justified and DSP. Each is timed against the word clock. Software chooses the word length, the frame length and a start delay of 0 to 255 bit clocks. With these settings several transmitters can take turns on one line, each in its own slot. For every bit clock outside its slot, the block either releases the line or holds it low. Each channel picks its own payload from five parallel sources or from two fixed combinations of them. Payloads shorter than the word are padded with zeros.

For the I2S, left-justified and right-justified formats, data changes on the falling bit clock edge and is sampled on the rising edge. For DSP, data changes on the rising edge and is sampled on the falling edge. The word clock is expected to change together with the drive edge. Configuration inputs must be held steady while frames are running.

Top module: `sptx_top`

## Requirements
- R1: The word length code selects the bits per channel word: 00 = 16, 01 = 20, 10 = 24, 11 = 32. Every word is sent most significant bit first.
- R2: The frame length code selects the bit clocks per frame: 00 = 32, 01 = 64, 10 = 128, 11 = 256. Half of this value is one channel period in the two-phase formats.
- R3: Format code 00 selects I2S. The left channel starts when the word clock falls and the right channel starts when it rises. With a delay of 0, the MSB is taken at the second sampling edge after the word clock edge.
- R4: Format code 11 selects left-justified. The left channel starts when the word clock rises and the right channel starts when it falls. With a delay of 0, the MSB is taken at the first sampling edge after the word clock edge.
- R5: Format code 10 selects right-justified. Channels follow the word clock levels as in R4. The channel LSB is taken at the last sampling edge before the word clock edge that ends the channel. The start delay is not applied in this format.
- R6: Format code 01 selects DSP. A rising word clock starts the frame. The left word is followed at once by the right word. Bits change on the rising bit clock edge and are taken on the falling edge.
- R7: In I2S, left-justified and DSP, the 8-bit start delay pushes the MSB back by 0 to 255 bit clocks. Bits that would fall past the end of the channel period (or, in DSP, past the end of the frame) are not sent.
- R8: On any bit clock that carries no word bit, the line is released (enable 0) when the idle-release control is 1. When that control is 0, the line is driven to 0.
- R9: The 3-bit payload select of each channel chooses its content: 000 = current (16 bits), 001 = voltage (16), 010 = battery level (8), 011 = boost level (8), 100 = gain (5), 101 = current then voltage (32), 110 = battery, boost then gain (21).
- R10: Word bits beyond the payload length are sent as 0. A payload longer than the word is cut after its first word-length bits.
- R11: Payload select 111 releases the line for that channel's whole word, whatever the idle-release control says.
- R12: All sources are captured at each frame start (I2S: word clock fall; other formats: word clock rise). A source change later in the frame does not alter any bit of that frame.
- R13: After reset, the enable and the data are 0. Nothing is driven until the first channel start edge.
- R14: Data and enable change only in the system clock cycle that follows a detected drive edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Bit clock from the external master |
| wclk | input | 1 | Word clock from the external master |
| cfg_fmt | input | 2 | Frame format code (R3 to R6) |
| cfg_wlen | input | 2 | Word length code (R1) |
| cfg_flen | input | 2 | Frame length code (R2) |
| cfg_offset | input | OFF_W (8) | Start delay in bit clocks |
| cfg_idle_hiz | input | 1 | 1 = release the line on idle bit clocks, 0 = drive low |
| cfg_sel_left | input | 3 | Left channel payload select |
| cfg_sel_right | input | 3 | Right channel payload select |
| src_i | input | I_W (16) | Current sense word |
| src_v | input | V_W (16) | Voltage sense word |
| src_vbat | input | VBAT_W (8) | Battery level |
| src_vboost | input | VBOOST_W (8) | Boost level |
| src_gain | input | GAIN_W (5) | Gain status |
| sd_out | output | 1 | Serial data bit |
| sd_oe | output | 1 | Output enable for the data pin |

## Verification
Two things happen on the same drive edge at the start of every frame. The sources are captured into the shadow register, and, in left-justified format with no delay, the first bit of the left word is emitted. The emitted MSB must therefore come from the live inputs, not from the stale shadow copy.

To provoke this, the bench changes every source a quarter of the way into a frame. It predicts that frame entirely from the values present at its start and predicts the next frame from the new values. It then compares each bit clock twice: once before the sampling edge and once in the following half period. A mismatch in either the captured word or the frame-start MSB therefore shows up as a bit error.

// File: rtl/sptx_pkg.sv
package sptx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S = 2'b00,
      FMT_DSP = 2'b01,
      FMT_RJ  = 2'b10,
      FMT_LJ  = 2'b11
   } fmt_e;

   typedef enum logic [2:0] {
      SEL_I    = 3'b000,
      SEL_V    = 3'b001,
      SEL_VBAT = 3'b010,
      SEL_VBST = 3'b011,
      SEL_GAIN = 3'b100,
      SEL_IV   = 3'b101,
      SEL_STAT = 3'b110,
      SEL_OFF  = 3'b111
   } sel_e;

   function automatic logic [6:0] word_bits(input logic [1:0] code);
      case (code)
         2'b00:   return 7'd16;
         2'b01:   return 7'd20;
         2'b10:   return 7'd24;
         default: return 7'd32;
      endcase
   endfunction

   function automatic logic [8:0] frame_bits(input logic [1:0] code);
      return 9'd32 << code;
   endfunction

endpackage

// File: rtl/sptx_edges.sv
module sptx_edges #(
   parameter int IN_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic wclk,
   input  logic drive_on_rise,
   output logic drive_stb,
   output logic wclk_rise,
   output logic wclk_fall,
   output logic wclk_lvl
);

   logic b_s, w_s, b_q, w_q;

   generate
      if (IN_SYNC < 0) begin : g_bad
         $error("sptx_edges: IN_SYNC must not be negative");
      end
      if (IN_SYNC == 0) begin : g_direct
         assign b_s = bclk;
         assign w_s = wclk;
      end else begin : g_sync
         logic [IN_SYNC-1:0] b_ch, w_ch;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               b_ch <= '0;
               w_ch <= '0;
            end else begin
               b_ch <= (b_ch << 1) | IN_SYNC'(bclk);
               w_ch <= (w_ch << 1) | IN_SYNC'(wclk);
            end
         end
         assign b_s = b_ch[IN_SYNC-1];
         assign w_s = w_ch[IN_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_q <= 1'b0;
         w_q <= 1'b0;
      end else begin
         b_q <= b_s;
         w_q <= w_s;
      end
   end

   assign drive_stb = drive_on_rise ? (b_s & ~b_q) : (~b_s & b_q);
   assign wclk_rise = w_s & ~w_q;
   assign wclk_fall = ~w_s & w_q;
   assign wclk_lvl  = w_s;

endmodule

// File: rtl/sptx_timer.sv
module sptx_timer
   import sptx_pkg::*;
#(
   parameter int WORD_MAX = 32,
   parameter int OFF_W    = 8,
   localparam int CNT_W   = $clog2((1 << OFF_W) + 2 * WORD_MAX + 1),
   localparam int IDX_W   = $clog2(WORD_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  fmt_e             fmt,
   input  logic [1:0]       wlen_code,
   input  logic [1:0]       flen_code,
   input  logic [OFF_W-1:0] offset,
   input  logic             drive_stb,
   input  logic             wclk_rise,
   input  logic             wclk_fall,
   input  logic             wclk_lvl,
   output logic             win,
   output logic             right,
   output logic [IDX_W-1:0] bit_idx,
   output logic             frame_cap
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt, pos_n, st, lim, w, half, fb, o;
   logic             ch_start;

   always_comb begin
      w    = CNT_W'(word_bits(wlen_code));
      fb   = CNT_W'(frame_bits(flen_code));
      half = fb >> 1;
      o    = CNT_W'(offset);
      ch_start = (fmt == FMT_DSP) ? wclk_rise : (wclk_rise | wclk_fall);
      if (ch_start)            pos_n = '0;
      else if (cnt == CNT_MAX) pos_n = CNT_MAX;
      else                     pos_n = cnt + CNT_W'(1);
      right = 1'b0;
      st    = '0;
      lim   = half;
      unique case (fmt)
         FMT_I2S: begin
            right = wclk_lvl;
            st    = o + CNT_W'(1);
         end
         FMT_LJ: begin
            right = ~wclk_lvl;
            st    = o;
         end
         FMT_RJ: begin
            right = ~wclk_lvl;
            st    = (half > w) ? half - w : '0;
         end
         FMT_DSP: begin
            right = (pos_n >= o + w);
            st    = right ? o + w : o;
            lim   = fb;
         end
      endcase
      win       = drive_stb && (pos_n >= st) && (pos_n < st + w) && (pos_n < lim);
      bit_idx   = IDX_W'(pos_n - st);
      frame_cap = drive_stb && ((fmt == FMT_I2S) ? wclk_fall : wclk_rise);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt <= CNT_MAX;
      else if (drive_stb) cnt <= pos_n;
   end

   // the position counter stays parked until a channel start edge arrives
   p_park_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_stb && !ch_start && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

   // a bit inside the window never indexes past the word length
   p_idx_in_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
      win |-> (CNT_W'(bit_idx) < w));

endmodule

// File: rtl/sptx_payload.sv
module sptx_payload
   import sptx_pkg::*;
#(
   parameter int I_W      = 16,
   parameter int V_W      = 16,
   parameter int VBAT_W   = 8,
   parameter int VBOOST_W = 8,
   parameter int GAIN_W   = 5,
   parameter int WORD_MAX = 32,
   localparam int IDX_W   = $clog2(WORD_MAX),
   localparam int LEN_W   = $clog2(WORD_MAX + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cap,
   input  logic [I_W-1:0]      src_i,
   input  logic [V_W-1:0]      src_v,
   input  logic [VBAT_W-1:0]   src_vbat,
   input  logic [VBOOST_W-1:0] src_vboost,
   input  logic [GAIN_W-1:0]   src_gain,
   input  logic [2:0]          sel_left,
   input  logic [2:0]          sel_right,
   input  logic                right,
   input  logic [IDX_W-1:0]    bit_idx,
   output logic                bit_val,
   output logic                present,
   output logic [LEN_W-1:0]    plen
);

   localparam int LEN_IV   = I_W + V_W;
   localparam int LEN_STAT = VBAT_W + VBOOST_W + GAIN_W;

   generate
      if (LEN_IV > WORD_MAX || LEN_STAT > WORD_MAX) begin : g_bad
         $error("sptx_payload: combined payload wider than WORD_MAX");
      end
   endgenerate

   logic [I_W-1:0]      sh_i,    ef_i;
   logic [V_W-1:0]      sh_v,    ef_v;
   logic [VBAT_W-1:0]   sh_vbat, ef_vbat;
   logic [VBOOST_W-1:0] sh_vbst, ef_vbst;
   logic [GAIN_W-1:0]   sh_gain, ef_gain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_i    <= '0;
         sh_v    <= '0;
         sh_vbat <= '0;
         sh_vbst <= '0;
         sh_gain <= '0;
      end else if (cap) begin
         sh_i    <= src_i;
         sh_v    <= src_v;
         sh_vbat <= src_vbat;
         sh_vbst <= src_vboost;
         sh_gain <= src_gain;
      end
   end

   // the capture edge itself already serializes from the live sources
   assign ef_i    = cap ? src_i      : sh_i;
   assign ef_v    = cap ? src_v      : sh_v;
   assign ef_vbat = cap ? src_vbat   : sh_vbat;
   assign ef_vbst = cap ? src_vboost : sh_vbst;
   assign ef_gain = cap ? src_gain   : sh_gain;

   generate
      for (genvar c = 0; c < 2; c++) begin : g_ch
         logic [2:0]          sel;
         logic [WORD_MAX-1:0] word;
         logic [LEN_W-1:0]    len;
         logic                pres;
         assign sel = (c == 0) ? sel_left : sel_right;
         always_comb begin
            word = '0;
            len  = '0;
            pres = 1'b1;
            case (sel_e'(sel))
               SEL_I: begin
                  word = WORD_MAX'(ef_i) << (WORD_MAX - I_W);
                  len  = LEN_W'(I_W);
               end
               SEL_V: begin
                  word = WORD_MAX'(ef_v) << (WORD_MAX - V_W);
                  len  = LEN_W'(V_W);
               end
               SEL_VBAT: begin
                  word = WORD_MAX'(ef_vbat) << (WORD_MAX - VBAT_W);
                  len  = LEN_W'(VBAT_W);
               end
               SEL_VBST: begin
                  word = WORD_MAX'(ef_vbst) << (WORD_MAX - VBOOST_W);
                  len  = LEN_W'(VBOOST_W);
               end
               SEL_GAIN: begin
                  word = WORD_MAX'(ef_gain) << (WORD_MAX - GAIN_W);
                  len  = LEN_W'(GAIN_W);
               end
               SEL_IV: begin
                  word = WORD_MAX'({ef_i, ef_v}) << (WORD_MAX - LEN_IV);
                  len  = LEN_W'(LEN_IV);
               end
               SEL_STAT: begin
                  word = WORD_MAX'({ef_vbat, ef_vbst, ef_gain}) << (WORD_MAX - LEN_STAT);
                  len  = LEN_W'(LEN_STAT);
               end
               default: pres = 1'b0;
            endcase
         end
      end
   endgenerate

   logic [WORD_MAX-1:0] word_sel;
   logic [IDX_W-1:0]    rev;

   always_comb begin
      word_sel = right ? g_ch[1].word : g_ch[0].word;
      plen     = right ? g_ch[1].len  : g_ch[0].len;
      present  = right ? g_ch[1].pres : g_ch[0].pres;
      rev      = IDX_W'(WORD_MAX - 1) - bit_idx;
      bit_val  = (LEN_W'(bit_idx) < plen) ? word_sel[rev] : 1'b0;
   end

   // shadow copy only moves on a frame start
   p_shadow_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> ($stable(sh_i) && $stable(sh_v) && $stable(sh_vbat)
                && $stable(sh_vbst) && $stable(sh_gain)));

endmodule

// File: rtl/sptx_top.sv
module sptx_top
   import sptx_pkg::*;
#(
   parameter int I_W      = 16,
   parameter int V_W      = 16,
   parameter int VBAT_W   = 8,
   parameter int VBOOST_W = 8,
   parameter int GAIN_W   = 5,
   parameter int WORD_MAX = 32,
   parameter int OFF_W    = 8,
   parameter int IN_SYNC  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bclk,
   input  logic                wclk,
   input  logic [1:0]          cfg_fmt,
   input  logic [1:0]          cfg_wlen,
   input  logic [1:0]          cfg_flen,
   input  logic [OFF_W-1:0]    cfg_offset,
   input  logic                cfg_idle_hiz,
   input  logic [2:0]          cfg_sel_left,
   input  logic [2:0]          cfg_sel_right,
   input  logic [I_W-1:0]      src_i,
   input  logic [V_W-1:0]      src_v,
   input  logic [VBAT_W-1:0]   src_vbat,
   input  logic [VBOOST_W-1:0] src_vboost,
   input  logic [GAIN_W-1:0]   src_gain,
   output logic                sd_out,
   output logic                sd_oe
);

   localparam int IDX_W = $clog2(WORD_MAX);
   localparam int LEN_W = $clog2(WORD_MAX + 1);

   generate
      if (WORD_MAX < 32) begin : g_bad_word
         $error("sptx_top: WORD_MAX must cover the 32-bit word code");
      end
      if (OFF_W < 1 || OFF_W > 12) begin : g_bad_off
         $error("sptx_top: OFF_W out of range");
      end
   endgenerate

   fmt_e             fmt;
   logic             drive_stb, wclk_rise, wclk_fall, wclk_lvl;
   logic             win, right, frame_cap, bit_val, present;
   logic [IDX_W-1:0] bit_idx;
   logic [LEN_W-1:0] plen;

   assign fmt = fmt_e'(cfg_fmt);

   sptx_edges #(.IN_SYNC(IN_SYNC)) u_edges (
      .clk           (clk),
      .rst_n         (rst_n),
      .bclk          (bclk),
      .wclk          (wclk),
      .drive_on_rise (fmt == FMT_DSP),
      .drive_stb     (drive_stb),
      .wclk_rise     (wclk_rise),
      .wclk_fall     (wclk_fall),
      .wclk_lvl      (wclk_lvl)
   );

   sptx_timer #(.WORD_MAX(WORD_MAX), .OFF_W(OFF_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt       (fmt),
      .wlen_code (cfg_wlen),
      .flen_code (cfg_flen),
      .offset    (cfg_offset),
      .drive_stb (drive_stb),
      .wclk_rise (wclk_rise),
      .wclk_fall (wclk_fall),
      .wclk_lvl  (wclk_lvl),
      .win       (win),
      .right     (right),
      .bit_idx   (bit_idx),
      .frame_cap (frame_cap)
   );

   sptx_payload #(
      .I_W(I_W), .V_W(V_W), .VBAT_W(VBAT_W), .VBOOST_W(VBOOST_W),
      .GAIN_W(GAIN_W), .WORD_MAX(WORD_MAX)
   ) u_payload (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap        (frame_cap),
      .src_i      (src_i),
      .src_v      (src_v),
      .src_vbat   (src_vbat),
      .src_vboost (src_vboost),
      .src_gain   (src_gain),
      .sel_left   (cfg_sel_left),
      .sel_right  (cfg_sel_right),
      .right      (right),
      .bit_idx    (bit_idx),
      .bit_val    (bit_val),
      .present    (present),
      .plen       (plen)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sd_out <= 1'b0;
         sd_oe  <= 1'b0;
      end else if (drive_stb) begin
         if (win && present) begin
            sd_oe  <= 1'b1;
            sd_out <= bit_val;
         end else if (win) begin
            sd_oe  <= 1'b0;
            sd_out <= 1'b0;
         end else begin
            sd_oe  <= ~cfg_idle_hiz;
            sd_out <= 1'b0;
         end
      end
   end

   p_hold_between_r14: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_stb |=> ($stable(sd_out) && $stable(sd_oe)));

   p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_stb && !win && cfg_idle_hiz) |=> !sd_oe);

   p_idle_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_stb && !win && !cfg_idle_hiz) |=> (sd_oe && !sd_out));

   p_off_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_stb && win && !present) |=> !sd_oe);

   p_pad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_stb && win && present && (LEN_W'(bit_idx) >= plen)) |=> !sd_out);

endmodule

// File: tb/sptx_top_tb.sv
module sptx_top_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        wclk = 1'b0;
   logic [1:0]  cfg_fmt = 2'b00, cfg_wlen = 2'b00, cfg_flen = 2'b01;
   logic [7:0]  cfg_offset = 8'd0;
   logic        cfg_idle_hiz = 1'b1;
   logic [2:0]  cfg_sel_left = 3'b000, cfg_sel_right = 3'b001;
   logic [15:0] s_i = 16'hA35C, s_v = 16'h1E87;
   logic [7:0]  s_vbat = 8'hC9, s_vbst = 8'h5B;
   logic [4:0]  s_gain = 5'b10110;
   logic        sd_out, sd_oe;

   always #2 clk = ~clk;

   sptx_top u_dut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk),
      .cfg_fmt(cfg_fmt), .cfg_wlen(cfg_wlen), .cfg_flen(cfg_flen),
      .cfg_offset(cfg_offset), .cfg_idle_hiz(cfg_idle_hiz),
      .cfg_sel_left(cfg_sel_left), .cfg_sel_right(cfg_sel_right),
      .src_i(s_i), .src_v(s_v), .src_vbat(s_vbat), .src_vboost(s_vbst),
      .src_gain(s_gain), .sd_out(sd_out), .sd_oe(sd_oe)
   );

   typedef struct { logic oe; logic d; int e; } exp_t;
   exp_t  q[$];
   event  smp;
   int    vectors = 0, fails = 0;
   bit    done = 1'b0;
   string tag = "";

   logic [15:0] f_i, f_v;
   logic [7:0]  f_vbat, f_vbst;
   logic [4:0]  f_gain;

   // scoreboard monitor
   initial begin
      forever begin
         @(smp);
         if (q.size() == 0) begin
            fails++;
            $display("FAIL %s: scoreboard empty, got oe=%b out=%b expected an entry", tag, sd_oe, sd_out);
         end else begin
            exp_t x;
            x = q.pop_front();
            vectors++;
            if (sd_oe !== x.oe || (x.oe && sd_out !== x.d)) begin
               fails++;
               $display("FAIL %s edge %0d: oe/out=%b/%b expected %b/%b", tag, x.e, sd_oe, sd_out, x.oe, x.d);
            end
         end
      end
   end

   function automatic logic [31:0] pword(input logic [2:0] sel, output int len);
      case (sel)
         3'd0: begin pword = {f_i, 16'h0};                 len = 16; end
         3'd1: begin pword = {f_v, 16'h0};                 len = 16; end
         3'd2: begin pword = {f_vbat, 24'h0};              len = 8;  end
         3'd3: begin pword = {f_vbst, 24'h0};              len = 8;  end
         3'd4: begin pword = {f_gain, 27'h0};              len = 5;  end
         3'd5: begin pword = {f_i, f_v};                   len = 32; end
         3'd6: begin pword = {f_vbat, f_vbst, f_gain, 11'h0}; len = 21; end
         default: begin pword = 32'h0;                     len = 0;  end
      endcase
   endfunction

   function automatic int wl(input logic [1:0] c);
      case (c)
         2'd0: return 16;
         2'd1: return 20;
         2'd2: return 24;
         default: return 32;
      endcase
   endfunction

   // expected {oe, data} for the sampling edge after drive edge e of a frame
   function automatic logic [1:0] ref_bit(input int e);
      int F, H, W, o, p, st, lim, len, j;
      bit rgt;
      logic [2:0]  sel;
      logic [31:0] wd;
      F = 32 << cfg_flen; H = F / 2; W = wl(cfg_wlen); o = cfg_offset;
      if (cfg_fmt == 2'b01) begin
         p = e; lim = F; rgt = (p >= o + W); st = rgt ? o + W : o;
      end else begin
         rgt = (e >= H); p = rgt ? e - H : e; lim = H;
         if (cfg_fmt == 2'b00)      st = o + 1;
         else if (cfg_fmt == 2'b11) st = o;
         else                       st = (H > W) ? H - W : 0;
      end
      if (p >= st && p < st + W && p < lim) begin
         sel = rgt ? cfg_sel_right : cfg_sel_left;
         if (sel == 3'b111) return 2'b00;
         wd = pword(sel, len);
         j  = p - st;
         return {1'b1, (j < len) ? wd[31 - j] : 1'b0};
      end
      return {~cfg_idle_hiz, 1'b0};
   endfunction

   task automatic run_frame(input bit mutate);
      int F, H;
      bit dsp;
      F = 32 << cfg_flen; H = F / 2; dsp = (cfg_fmt == 2'b01);
      f_i = s_i; f_v = s_v; f_vbat = s_vbat; f_vbst = s_vbst; f_gain = s_gain;
      for (int e = 0; e < F; e++) begin
         exp_t x;
         logic [1:0] r;
         if (mutate && e == F / 4) begin
            s_i = ~s_i; s_v = s_v ^ 16'h5A5A; s_vbat = s_vbat + 8'd37;
            s_vbst = ~s_vbst; s_gain = s_gain ^ 5'b01101;
         end
         if (dsp)                    wclk = (e == 0);
         else if (cfg_fmt == 2'b00)  wclk = (e >= H);
         else                        wclk = (e < H);
         bclk = dsp;
         r = ref_bit(e);
         x.oe = r[1]; x.d = r[0]; x.e = e;
         q.push_back(x);
         q.push_back(x);
         repeat (5) @(negedge clk);
         -> smp;
         @(negedge clk);
         bclk = ~dsp;
         repeat (5) @(negedge clk);
         -> smp;
         @(negedge clk);
      end
   endtask

   task automatic group(input logic [1:0] fmt, input logic [1:0] wlen, input logic [1:0] flen,
                        input logic [7:0] off, input logic hiz, input logic [2:0] sl,
                        input logic [2:0] sr, input int frames, input bit mut, input string t);
      cfg_fmt = fmt; cfg_wlen = wlen; cfg_flen = flen; cfg_offset = off;
      cfg_idle_hiz = hiz; cfg_sel_left = sl; cfg_sel_right = sr;
      rst_n = 1'b0;
      bclk  = (fmt != 2'b01);
      wclk  = (fmt == 2'b00);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      vectors++;
      if (sd_oe !== 1'b0 || sd_out !== 1'b0) begin
         fails++;
         $display("FAIL R13 reset: oe/out=%b/%b expected 0/0", sd_oe, sd_out);
      end
      tag = t;
      for (int k = 0; k < frames; k++) run_frame(mut && k == 0);
   endtask

   initial begin
      // I2S, 16-bit words in a 64-clock frame, current left, voltage right
      group(2'b00, 2'b00, 2'b01, 8'd0,   1'b1, 3'd0, 3'd1, 2, 1'b0, "R3/R9/R8/R14");
      // left-justified, 24-bit words, short payloads padded, idle driven low
      group(2'b11, 2'b10, 2'b01, 8'd0,   1'b0, 3'd2, 3'd4, 2, 1'b0, "R4/R1/R10/R8");
      // right-justified, 128-clock frame, delay ignored, 21-bit payload cut to 16
      group(2'b10, 2'b00, 2'b10, 8'd5,   1'b1, 3'd6, 3'd3, 1, 1'b0, "R5/R2/R10/R9");
      // DSP, 20-bit words, delay 3, 32-bit payload truncated
      group(2'b01, 2'b01, 2'b01, 8'd3,   1'b0, 3'd5, 3'd0, 2, 1'b0, "R6/R7/R1");
      // I2S slot at delay 40, 32-bit words, right channel disabled
      group(2'b00, 2'b11, 2'b11, 8'd40,  1'b1, 3'd5, 3'd7, 1, 1'b0, "R7/R11/R1");
      // disabled channel with idle driven low still releases the line
      group(2'b11, 2'b00, 2'b00, 8'd0,   1'b0, 3'd7, 3'd1, 1, 1'b0, "R11/R8");
      // sources change mid-frame, left-justified zero delay
      group(2'b11, 2'b00, 2'b00, 8'd0,   1'b1, 3'd0, 3'd1, 2, 1'b1, "R12/R4");
      // maximum delay in DSP, only the left MSB fits in the frame
      group(2'b01, 2'b00, 2'b11, 8'd255, 1'b0, 3'd0, 3'd1, 1, 1'b0, "R7/R6/R2");
      repeat (4) @(negedge clk);
      if (q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard: %0d entries left, expected 0", q.size());
      end
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule